// File: doc/BRIEF.md
# Dual-Plane Erase Suspend Sequencer

This block keeps track of the embedded program and erase operations inside a flash array of 40 sectors that is split into two planes. It takes operation requests that have already been decoded: sector erase, chip erase, program, suspend and resume. It also takes a lockout bit for each sector and a plain override flag that lifts every lockout. Real erase and program timing is replaced by cycle counters whose lengths are parameters. For each plane the block reports whether it is busy and whether it holds a suspended erase. A one-cycle completion pulse carries a mask of the sectors whose contents the finished operation actually changed.

The sequencer also rules on two kinds of access. It tells the command decoder whether each request was accepted. It answers a read-legality query for any sector, so that reads can be steered to the idle plane while the other plane works. While an erase is on hold, the same query limits reads to the sectors the held erase does not touch. Only one embedded operation runs at a time, with one exception: a program may run while an erase is held.

Top module: `ses_dual_plane_seq`

## Requirements
- R1: A synchronous active-high reset clears busy, suspended, done, done_mask, req_acc and rd_ok. A reset asserted during an operation abandons it, and no done pulse follows.
- R2: A sector erase accepted when the block is idle keeps busy of the target's plane high for SECT_CYC cycles. It then gives a one-cycle done pulse with only the target's bit set in done_mask.
- R3: While one plane is busy, a read query to a sector of the other plane returns rd_ok=1 one cycle later. A query to the busy plane returns 0.
- R4: A sector erase aimed at a locked sector, with hv_override low, completes after LOCK_CYC cycles and leaves done_mask all zero. With hv_override high it runs the full SECT_CYC and sets the target's bit.
- R5: A chip erase sets both busy bits for CHIP_CYC cycles. Its done_mask holds exactly the sectors that were not protected when it started.
- R6: A suspend request carries no address. It is accepted only while an erase is running with time still left. busy stays high until suspended rises SUSP_CYC cycles after acceptance. Once suspended is high, that plane's busy bit drops.
- R7: While an erase is held, sector and chip erase requests are refused. A program to the held erase's target is refused. A program to an unlocked other sector is accepted. Read queries to other sectors return 1, and a query to the target returns 0.
- R8: A resume whose req_plane differs from the held sector's plane is refused, and the erase stays held. A matching resume restarts the erase, which finishes after the remaining count. Erase time counted before the hold plus time counted after it totals SECT_CYC.
- R9: Every request made while a program is running is refused (req_acc=0).
- R10: A program lasts PROG_CYC cycles, and its done_mask carries the target's bit. A program to a sector that is locked while hv_override is low is refused.
- R11: A chip erase can be held. While it is held, reads are legal only to protected sectors and no program is accepted. A resume naming either plane restarts it.
- R12: req_op encoding: 0 none, 1 sector erase, 2 chip erase, 3 program, 4 suspend, 5 resume. Sectors below PLANE0_SECTS belong to plane 0 and the rest to plane 1. Bit 0 of busy and suspended is plane 0. Request sectors at or above NUM_SECT are refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_op | input | 3 | Operation code (R12) |
| req_sector | input | SECT_W | Target sector for erase and program |
| req_plane | input | 1 | Plane named by a resume |
| lock_vec | input | NUM_SECT | Lockout bit per sector |
| hv_override | input | 1 | Lifts all lockouts while high |
| rd_valid | input | 1 | Read-legality query strobe |
| rd_sector | input | SECT_W | Sector of the read query |
| req_acc | output | 1 | Request accepted, one cycle after the request |
| busy | output | 2 | Plane running an embedded operation |
| suspended | output | 2 | Plane holding a suspended erase |
| done | output | 1 | One-cycle completion pulse |
| done_mask | output | NUM_SECT | Sectors changed by the completed operation |
| rd_ok | output | 1 | Read legal, one cycle after the query |

## Verification
The bench builds the block with 40 sectors split 16 and 24. It sets SECT_CYC=20, CHIP_CYC=40, PROG_CYC=6, LOCK_CYC=3 and SUSP_CYC=4. With these short durations, every full completion, the early end of a locked erase and the suspend latency can be counted cycle by cycle. The bench can also measure the exact remaining count after a resume and compare it with the count spent before the hold. Sectors 3 (plane 0) and 30 (plane 1) are locked. This exercises the protection rules and the override in both planes, and it makes a nontrivial chip-erase mask.

// File: rtl/ses_pkg.sv
package ses_pkg;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_SERASE = 3'd1,
    OP_CERASE = 3'd2,
    OP_PROG   = 3'd3,
    OP_SUSP   = 3'd4,
    OP_RESUME = 3'd5
  } op_e;

  typedef enum logic [2:0] {
    ES_IDLE,
    ES_RUN,
    ES_SUSPING,
    ES_HELD,
    ES_ABORT
  } est_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/ses_plane_map.sv
module ses_plane_map #(
  parameter int NUM_SECT     = 40,
  parameter int PLANE0_SECTS = 16,
  localparam int SECT_W      = $clog2(NUM_SECT)
) (
  input  logic [SECT_W-1:0] sector,
  output logic              plane,
  output logic              in_range
);
  always_comb begin
    plane    = (int'(sector) >= PLANE0_SECTS);
    in_range = (int'(sector) < NUM_SECT);
  end
endmodule

// File: rtl/ses_erase_eng.sv
module ses_erase_eng
  import ses_pkg::*;
#(
  parameter int NUM_SECT = 40,
  parameter int SECT_CYC = 10_000_000,
  parameter int CHIP_CYC = 80_000_000,
  parameter int LOCK_CYC = 100,
  parameter int SUSP_CYC = 750,
  localparam int SECT_W  = $clog2(NUM_SECT),
  localparam int CW      = $clog2(max3(SECT_CYC, CHIP_CYC, LOCK_CYC) + 1),
  localparam int SCW     = $clog2(SUSP_CYC + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_sect,
  input  logic                start_chip,
  input  logic [SECT_W-1:0]   sector,
  input  logic                locked,
  input  logic [NUM_SECT-1:0] chip_mask,
  input  logic                susp_req,
  input  logic                res_req,
  output est_e                state,
  output logic [SECT_W-1:0]   tgt,
  output logic                is_chip,
  output logic                can_susp,
  output logic                done,
  output logic [NUM_SECT-1:0] done_mask
);
  logic [CW-1:0]       cnt;
  logic [SCW-1:0]      scnt;
  logic [NUM_SECT-1:0] mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ES_IDLE;
      cnt       <= '0;
      scnt      <= '0;
      tgt       <= '0;
      is_chip   <= 1'b0;
      mask      <= '0;
      done      <= 1'b0;
      done_mask <= '0;
    end else begin
      done      <= 1'b0;
      done_mask <= '0;
      unique case (state)
        ES_IDLE: begin
          if (start_chip) begin
            state   <= ES_RUN;
            cnt     <= CW'(CHIP_CYC - 1);
            is_chip <= 1'b1;
            mask    <= chip_mask;
          end else if (start_sect) begin
            tgt     <= sector;
            is_chip <= 1'b0;
            if (locked) begin
              state <= ES_ABORT;
              cnt   <= CW'(LOCK_CYC - 1);
              mask  <= '0;
            end else begin
              state <= ES_RUN;
              cnt   <= CW'(SECT_CYC - 1);
              mask  <= NUM_SECT'(1) << sector;
            end
          end
        end
        ES_RUN: begin
          if (cnt == '0) begin
            state     <= ES_IDLE;
            done      <= 1'b1;
            done_mask <= mask;
          end else begin
            cnt <= cnt - 1'b1;
            if (susp_req) begin
              state <= ES_SUSPING;
              scnt  <= SCW'(SUSP_CYC - 1);
            end
          end
        end
        ES_SUSPING: begin
          if (scnt == '0) state <= ES_HELD;
          else            scnt  <= scnt - 1'b1;
        end
        ES_HELD: begin
          if (res_req) state <= ES_RUN;
        end
        ES_ABORT: begin
          if (cnt == '0) begin
            state <= ES_IDLE;
            done  <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= ES_IDLE;
      endcase
    end
  end

  assign can_susp = (state == ES_RUN) && (cnt != '0);

endmodule

// File: rtl/ses_prog_eng.sv
module ses_prog_eng #(
  parameter int NUM_SECT = 40,
  parameter int PROG_CYC = 500,
  localparam int SECT_W  = $clog2(NUM_SECT),
  localparam int PW      = $clog2(PROG_CYC + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [SECT_W-1:0]   sector,
  output logic                running,
  output logic [SECT_W-1:0]   tgt,
  output logic                done,
  output logic [NUM_SECT-1:0] done_mask
);
  logic [PW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      running   <= 1'b0;
      cnt       <= '0;
      tgt       <= '0;
      done      <= 1'b0;
      done_mask <= '0;
    end else begin
      done      <= 1'b0;
      done_mask <= '0;
      if (!running) begin
        if (start) begin
          running <= 1'b1;
          tgt     <= sector;
          cnt     <= PW'(PROG_CYC - 1);
        end
      end else if (cnt == '0) begin
        running   <= 1'b0;
        done      <= 1'b1;
        done_mask <= NUM_SECT'(1) << tgt;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/ses_dual_plane_seq.sv
module ses_dual_plane_seq
  import ses_pkg::*;
#(
  parameter int NUM_SECT     = 40,
  parameter int PLANE0_SECTS = 16,
  parameter int SECT_CYC     = 10_000_000,
  parameter int CHIP_CYC     = 80_000_000,
  parameter int PROG_CYC     = 500,
  parameter int LOCK_CYC     = 100,
  parameter int SUSP_CYC     = 750,
  localparam int SECT_W      = $clog2(NUM_SECT)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic [2:0]          req_op,
  input  logic [SECT_W-1:0]   req_sector,
  input  logic                req_plane,
  input  logic [NUM_SECT-1:0] lock_vec,
  input  logic                hv_override,
  input  logic                rd_valid,
  input  logic [SECT_W-1:0]   rd_sector,
  output logic                req_acc,
  output logic [1:0]          busy,
  output logic [1:0]          suspended,
  output logic                done,
  output logic [NUM_SECT-1:0] done_mask,
  output logic                rd_ok
);
  localparam int NMAP = 4;

  // sector to plane decode for request, query, erase target and program target
  logic [NMAP-1:0][SECT_W-1:0] map_sec;
  logic [NMAP-1:0]             map_pl;
  logic [NMAP-1:0]             map_ok;

  est_e                e_state;
  logic [SECT_W-1:0]   e_tgt;
  logic                e_chip, e_can_susp, e_done;
  logic [NUM_SECT-1:0] e_mask;
  logic                p_run, p_done;
  logic [SECT_W-1:0]   p_tgt;
  logic [NUM_SECT-1:0] p_mask;

  assign map_sec[0] = req_sector;
  assign map_sec[1] = rd_sector;
  assign map_sec[2] = e_tgt;
  assign map_sec[3] = p_tgt;

  for (genvar g = 0; g < NMAP; g++) begin : g_map
    ses_plane_map #(.NUM_SECT(NUM_SECT), .PLANE0_SECTS(PLANE0_SECTS)) u_map (
      .sector  (map_sec[g]),
      .plane   (map_pl[g]),
      .in_range(map_ok[g])
    );
  end

  logic [NUM_SECT-1:0] prot_vec;
  logic req_prot, rd_prot;
  logic acc_serase, acc_cerase, acc_prog, acc_susp, acc_res;
  logic e_active, e_held;
  logic [1:0] e_planes, p_planes;
  logic rd_ok_d;

  always_comb begin
    prot_vec = lock_vec & {NUM_SECT{~hv_override}};
    req_prot = map_ok[0] ? prot_vec[req_sector] : 1'b1;
    rd_prot  = map_ok[1] ? prot_vec[rd_sector]  : 1'b1;
    e_active = (e_state == ES_RUN) || (e_state == ES_SUSPING) || (e_state == ES_ABORT);
    e_held   = (e_state == ES_HELD);

    acc_serase = req_valid && (req_op == OP_SERASE) && map_ok[0] && !p_run &&
                 (e_state == ES_IDLE);
    acc_cerase = req_valid && (req_op == OP_CERASE) && !p_run && (e_state == ES_IDLE);
    acc_prog   = req_valid && (req_op == OP_PROG) && map_ok[0] && !p_run && !req_prot &&
                 ((e_state == ES_IDLE) || (e_held && !e_chip && (req_sector != e_tgt)));
    acc_susp   = req_valid && (req_op == OP_SUSP) && !p_run && e_can_susp;
    acc_res    = req_valid && (req_op == OP_RESUME) && !p_run && e_held &&
                 (e_chip || (req_plane == map_pl[2]));

    e_planes  = e_chip ? 2'b11 : (2'b01 << map_pl[2]);
    p_planes  = 2'b01 << map_pl[3];
    busy      = (e_active ? e_planes : 2'b00) | (p_run ? p_planes : 2'b00);
    suspended = e_held ? e_planes : 2'b00;

    rd_ok_d = rd_valid && map_ok[1] && !busy[map_pl[1]] &&
              !(suspended[map_pl[1]] && (e_chip ? !rd_prot : (rd_sector == e_tgt)));
  end

  ses_erase_eng #(
    .NUM_SECT(NUM_SECT), .SECT_CYC(SECT_CYC), .CHIP_CYC(CHIP_CYC),
    .LOCK_CYC(LOCK_CYC), .SUSP_CYC(SUSP_CYC)
  ) u_erase (
    .clk       (clk),
    .rst       (rst),
    .start_sect(acc_serase),
    .start_chip(acc_cerase),
    .sector    (req_sector),
    .locked    (req_prot),
    .chip_mask (~prot_vec),
    .susp_req  (acc_susp),
    .res_req   (acc_res),
    .state     (e_state),
    .tgt       (e_tgt),
    .is_chip   (e_chip),
    .can_susp  (e_can_susp),
    .done      (e_done),
    .done_mask (e_mask)
  );

  ses_prog_eng #(.NUM_SECT(NUM_SECT), .PROG_CYC(PROG_CYC)) u_prog (
    .clk      (clk),
    .rst      (rst),
    .start    (acc_prog),
    .sector   (req_sector),
    .running  (p_run),
    .tgt      (p_tgt),
    .done     (p_done),
    .done_mask(p_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_acc <= 1'b0;
      rd_ok   <= 1'b0;
    end else begin
      req_acc <= acc_serase | acc_cerase | acc_prog | acc_susp | acc_res;
      rd_ok   <= rd_ok_d;
    end
  end

  assign done      = e_done | p_done;
  assign done_mask = e_mask | p_mask;

endmodule

// File: rtl/ses_dual_plane_seq_chk.sv
module ses_dual_plane_seq_chk #(
  parameter int NUM_SECT = 40
) (
  input logic                clk,
  input logic                rst,
  input logic                req_valid,
  input logic [2:0]          req_op,
  input logic                req_acc,
  input logic [1:0]          busy,
  input logic [1:0]          suspended,
  input logic                done,
  input logic [NUM_SECT-1:0] done_mask,
  input logic                p_run
);
  logic rst_q = 1'b0;
  always_ff @(posedge clk) rst_q <= rst;

  // R1: state cleared in the cycle after a reset edge
  always @(negedge clk) begin
    if (rst_q === 1'b1) begin
      a_r1_reset_clears: assert (busy == 2'b00 && suspended == 2'b00 && !done && !req_acc);
    end
  end

  a_r2_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r10_mask_only_on_done: assert property (@(posedge clk) disable iff (rst)
    !done |-> (done_mask == '0));

  a_r9_prog_ignores_requests: assert property (@(posedge clk) disable iff (rst)
    (p_run && req_valid) |=> !req_acc);

  a_r7_no_erase_while_held: assert property (@(posedge clk) disable iff (rst)
    ((suspended != 2'b00) && req_valid && (req_op == 3'd1 || req_op == 3'd2)) |=> !req_acc);

  a_r6_hold_after_busy_p0: assert property (@(posedge clk) disable iff (rst)
    $rose(suspended[0]) |-> $past(busy[0]));

  a_r6_hold_after_busy_p1: assert property (@(posedge clk) disable iff (rst)
    $rose(suspended[1]) |-> $past(busy[1]));

endmodule

bind ses_dual_plane_seq ses_dual_plane_seq_chk #(.NUM_SECT(NUM_SECT)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_op   (req_op),
  .req_acc  (req_acc),
  .busy     (busy),
  .suspended(suspended),
  .done     (done),
  .done_mask(done_mask),
  .p_run    (p_run)
);

// File: tb/ses_dual_plane_seq_test.sv
module ses_dual_plane_seq_test;
  localparam int NS   = 40;
  localparam int P0   = 16;
  localparam int SECT = 20;
  localparam int CHIP = 40;
  localparam int PROG = 6;
  localparam int LOCK = 3;
  localparam int SUSP = 4;
  localparam int SW   = $clog2(NS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [2:0] req_op = 3'd0;
  logic [SW-1:0] req_sector = '0;
  logic req_plane = 1'b0;
  logic [NS-1:0] lock_vec;
  logic hv_override = 1'b0;
  logic rd_valid = 1'b0;
  logic [SW-1:0] rd_sector = '0;
  logic req_acc, done, rd_ok;
  logic [1:0] busy, suspended;
  logic [NS-1:0] done_mask;

  int nchk = 0;
  int nerr = 0;
  bit ended = 1'b0;

  always #5 clk = ~clk;

  ses_dual_plane_seq #(
    .NUM_SECT(NS), .PLANE0_SECTS(P0), .SECT_CYC(SECT), .CHIP_CYC(CHIP),
    .PROG_CYC(PROG), .LOCK_CYC(LOCK), .SUSP_CYC(SUSP)
  ) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_sector(req_sector), .req_plane(req_plane), .lock_vec(lock_vec),
    .hv_override(hv_override), .rd_valid(rd_valid), .rd_sector(rd_sector),
    .req_acc(req_acc), .busy(busy), .suspended(suspended), .done(done),
    .done_mask(done_mask), .rd_ok(rd_ok)
  );

  typedef struct packed {
    logic [2:0] op;
    logic [5:0] sec;
    logic       ovr;
    logic       acc;
    logic [7:0] len;
    logic       hit;
  } vec_t;

  // R12 encodings: 1 sector erase, 2 chip erase, 3 program, 4 suspend, 5 resume
  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{3'd1, 6'd5,  1'b0, 1'b1, 8'd20, 1'b1},  // R2 plain sector erase
    '{3'd1, 6'd3,  1'b0, 1'b1, 8'd3,  1'b0},  // R4 locked, cut short
    '{3'd1, 6'd3,  1'b1, 1'b1, 8'd20, 1'b1},  // R4 locked with override
    '{3'd3, 6'd20, 1'b0, 1'b1, 8'd6,  1'b1},  // R10 program
    '{3'd3, 6'd30, 1'b0, 1'b0, 8'd0,  1'b0},  // R10 program locked refused
    '{3'd3, 6'd30, 1'b1, 1'b1, 8'd6,  1'b1},  // R10 program with override
    '{3'd4, 6'd0,  1'b0, 1'b0, 8'd0,  1'b0},  // R6 suspend when idle
    '{3'd5, 6'd0,  1'b0, 1'b0, 8'd0,  1'b0},  // R8 resume when idle
    '{3'd2, 6'd0,  1'b0, 1'b1, 8'd40, 1'b1},  // R5 chip erase
    '{3'd1, 6'd39, 1'b0, 1'b1, 8'd20, 1'b1},  // R12 top sector, plane 1
    '{3'd1, 6'd45, 1'b0, 1'b0, 8'd0,  1'b0}   // R12 out of range refused
  };

  task automatic summary();
    if (!ended) begin
      ended = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  endtask

  task automatic chk(input string tag, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the accepting edge
  task automatic req(input logic [2:0] op, input int sec, input logic pl);
    req_valid  = 1'b1;
    req_op     = op;
    req_sector = SW'(sec);
    req_plane  = pl;
    @(negedge clk);
    req_valid  = 1'b0;
    req_op     = 3'd0;
  endtask

  task automatic query(input int sec, output logic ok);
    rd_valid  = 1'b1;
    rd_sector = SW'(sec);
    @(negedge clk);
    ok = rd_ok;
    rd_valid = 1'b0;
  endtask

  task automatic wait_done(output int k);
    k = 0;
    while (!done && k < 500) begin
      @(negedge clk);
      k++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int k;
    logic ok;
    logic [NS-1:0] exp_chip;
    lock_vec = '0;
    lock_vec[3]  = 1'b1;
    lock_vec[30] = 1'b1;
    exp_chip = ~lock_vec;

    repeat (3) @(negedge clk);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset suspended", suspended, 0);
    chk("R1 reset done", done, 0);
    chk("R1 reset acc", req_acc, 0);
    chk("R1 reset rd_ok", rd_ok, 0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      hv_override = VECS[i].ovr;
      req(VECS[i].op, int'(VECS[i].sec), 1'b0);
      chk($sformatf("R12 vec %0d acc", i), req_acc, VECS[i].acc);
      if (VECS[i].acc) begin
        wait_done(k);
        chk($sformatf("R2 vec %0d length", i), k, VECS[i].len);
        chk($sformatf("R4 vec %0d mask bit", i), done_mask[VECS[i].sec], VECS[i].hit);
      end
      @(negedge clk);
      hv_override = 1'b0;
    end

    // R5 chip erase busy and mask
    req(3'd2, 0, 1'b0);
    chk("R5 both planes busy", busy, 2'b11);
    wait_done(k);
    chk("R5 chip length", k, CHIP);
    chk("R5 chip mask", done_mask, exp_chip);
    @(negedge clk);

    // R3 read the idle plane while the other erases
    req(3'd1, 5, 1'b0);
    chk("R3 plane0 busy", busy, 2'b01);
    query(20, ok);
    chk("R3 read other plane", ok, 1);
    query(6, ok);
    chk("R3 read busy plane", ok, 0);
    wait_done(k);
    @(negedge clk);

    // R6 R7 R8 R9 suspend of a sector erase
    req(3'd1, 5, 1'b0);
    repeat (4) @(negedge clk);
    req(3'd4, 0, 1'b0);
    chk("R6 suspend acc", req_acc, 1);
    chk("R6 busy during suspend latency", busy, 2'b01);
    chk("R6 not yet held", suspended, 0);
    k = 0;
    while (!suspended[0] && k < 100) begin
      @(negedge clk);
      k++;
    end
    chk("R6 suspend latency", k, SUSP);
    chk("R6 busy drops when held", busy, 0);
    req(3'd1, 8, 1'b0);
    chk("R7 sector erase refused", req_acc, 0);
    req(3'd2, 0, 1'b0);
    chk("R7 chip erase refused", req_acc, 0);
    req(3'd3, 5, 1'b0);
    chk("R7 program target refused", req_acc, 0);
    query(5, ok);
    chk("R7 read target", ok, 0);
    query(6, ok);
    chk("R7 read same plane other sector", ok, 1);
    query(25, ok);
    chk("R7 read other plane", ok, 1);
    req(3'd3, 7, 1'b0);
    chk("R7 program other sector acc", req_acc, 1);
    chk("R7 program busy plane0", busy, 2'b01);
    chk("R7 still held", suspended, 2'b01);
    req(3'd5, 0, 1'b0);
    chk("R9 resume during program", req_acc, 0);
    req(3'd1, 20, 1'b0);
    chk("R9 erase during program", req_acc, 0);
    wait_done(k);
    chk("R10 program mask", done_mask[7], 1);
    @(negedge clk);
    req(3'd5, 0, 1'b1);
    chk("R8 wrong plane resume", req_acc, 0);
    chk("R8 stays held", suspended, 2'b01);
    req(3'd5, 0, 1'b0);
    chk("R8 resume acc", req_acc, 1);
    chk("R8 busy again", busy, 2'b01);
    chk("R8 released", suspended, 0);
    wait_done(k);
    chk("R8 remaining count", k, SECT - 5);
    chk("R8 erase mask", done_mask, longint'(1) << 5);
    @(negedge clk);

    // R11 chip erase suspend
    req(3'd2, 0, 1'b0);
    repeat (2) @(negedge clk);
    req(3'd4, 0, 1'b0);
    chk("R11 chip suspend acc", req_acc, 1);
    k = 0;
    while (suspended != 2'b11 && k < 100) begin
      @(negedge clk);
      k++;
    end
    chk("R11 both held", suspended, 2'b11);
    query(3, ok);
    chk("R11 read protected", ok, 1);
    query(5, ok);
    chk("R11 read unprotected p0", ok, 0);
    query(20, ok);
    chk("R11 read unprotected p1", ok, 0);
    req(3'd3, 20, 1'b0);
    chk("R11 program refused", req_acc, 0);
    req(3'd5, 0, 1'b1);
    chk("R11 resume either plane", req_acc, 1);
    wait_done(k);
    chk("R11 chip mask after resume", done_mask, exp_chip);
    @(negedge clk);

    // R1 reset during an erase
    req(3'd1, 10, 1'b0);
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid-op busy cleared", busy, 0);
    rst = 1'b0;
    k = 0;
    for (int c = 0; c < SECT + 5; c++) begin
      @(negedge clk);
      if (done) k++;
    end
    chk("R1 no done after abort", k, 0);

    summary();
  end
endmodule